// File: doc/BRIEF.md
# Dual-clock 8-bit timer with staged register writes

This block is an 8-bit up-counter whose counting logic is clocked by a timer clock. That clock is either the system clock or a separate slow oscillator, and a bit in the status register chooses between them. Software reaches the block through a simple register port on the system clock. The three timer registers are the count, the compare value and the control byte. A write to any of them lands first in a staging register that belongs to that register alone. The timer clock then picks the value up and installs it. Until that happens, the status register shows the write as busy, so software can wait for it before relying on the new setting.

The timer clock domain detects wrap-around and compare-match events. They cross back to the system clock as toggles and set two sticky flags. Software clears a flag by writing a one to its bit. Each flag drives an interrupt line through its own enable bit. While a count or compare update is still in flight, the compare matcher is held off so that it cannot match against a stale pairing.

Register map (one address port for reads and writes, read data combinational): 0 count, 1 compare, 2 control, 3 status, 4 flags, 5 interrupt enables.

Top module: `async_timer`

## Requirements
- R1: A write to address 0, 1 or 2 sets status bit 2, 1 or 0 respectively on the next system clock. That bit stays 1 until the value is installed and the installation is reported back, then reads 0.
- R2: A written count, compare or control value is installed on the second rising edge of the timer clock after the write. After only one such edge, reading address 0, 1 or 2 still returns the old value.
- R3: The three staging paths are independent: writes to count, compare and control issued on consecutive cycles all land with their own values.
- R4: Writing the same register again while its status bit is 1 replaces the staged value. The status bit stays 1 until the last written value is installed, and that value is what reads back.
- R5: Status bit 3 is writable and selects the timer clock: 0 for the system clock, 1 for the oscillator input `tosc`.
- R6: The count increments by one per timer clock edge while control bits 2:0 are non-zero, and holds its value while they are zero.
- R7: The count wraps from 0xFF to 0x00, and that wrap sets flags bit 0 (overflow).
- R8: Flags bit 1 (compare) is set when, at a timer clock edge with the counter running, the count equals the compare value.
- R9: No compare match is taken at a timer clock edge while a count or compare write is still in flight in the timer domain.
- R10: Writing a 1 to a bit of address 4 clears that flag. Writing 0 leaves it unchanged.
- R11: `irq_ovf` is flags bit 0 AND enable bit 0, and `irq_cmp` is flags bit 1 AND enable bit 1, where the enables are address 5 bits 0 and 1.
- R12: Reset clears the count, compare, control, clock select, enables, flags and busy bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| tosc | input | 1 | Slow oscillator, usable as timer clock |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq_ovf | output | 1 | Overflow interrupt |
| irq_cmp | output | 1 | Compare interrupt |

## Verification
The assertions check several properties on every clock edge. On the system clock, a write raises its busy bit on the following cycle, and a flag falls only after a write of one to it. On the timer clock, a pending transfer installs exactly the staged value, a running counter steps by one, a step from 0xFF toggles the overflow event, and no compare event is produced while a count or compare write is in flight. The end-to-end behaviour can only be shown by the bench scenarios. These cover the two-edge landing latency measured against real oscillator edges, the overwrite of a write that has already been picked up, the exact cycle in which the overflow and compare flags become visible on the bus, the suppressed match, and the interrupt gating.

// File: rtl/async_timer.sv
`timescale 1ns/1ps
module async_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tosc,
  input  logic         wr_en,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         irq_ovf,
  output logic         irq_cmp
);
  localparam logic [2:0] A_CNT = 3'd0, A_CMP = 3'd1, A_CTL = 3'd2,
                         A_STAT = 3'd3, A_FLAG = 3'd4, A_EN = 3'd5;

  // index 2 = count, 1 = compare, 0 = control
  logic [2:0][W-1:0] stage;
  logic [2:0] req, again, ks1, ks2, busy, wsel;
  logic       sel;
  logic [1:0] flag, en, e1, e2, e3, evt, clr;

  logic         tclk, run, supp;
  logic [2:0]   cap, ack, ld;
  logic [W-1:0] cnt, cmp_t, ctl_t;
  logic         ovf_tg, cmp_tg;

  assign wsel = {wr_en && addr == A_CNT, wr_en && addr == A_CMP, wr_en && addr == A_CTL};
  assign busy = (req ^ ks2) | again;
  assign evt  = e2 ^ e3;
  assign clr  = (wr_en && addr == A_FLAG) ? wdata[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= '0; req <= '0; again <= '0; ks1 <= '0; ks2 <= '0;
      sel <= 1'b0; en <= '0; flag <= '0; e1 <= '0; e2 <= '0; e3 <= '0;
    end else begin
      ks1 <= ack;
      ks2 <= ks1;
      e1  <= {cmp_tg, ovf_tg};
      e2  <= e1;
      e3  <= e2;
      for (int i = 0; i < 3; i++) begin
        if (wsel[i]) begin
          stage[i] <= wdata;
          if (busy[i]) again[i] <= 1'b1;
          else         req[i]   <= ~req[i];
        end else if (again[i] && req[i] == ks2[i]) begin
          req[i]   <= ~req[i];
          again[i] <= 1'b0;
        end
      end
      if (wr_en && addr == A_STAT) sel <= wdata[3];
      if (wr_en && addr == A_EN)   en  <= wdata[1:0];
      flag <= (flag & ~clr) | evt;
    end
  end

  assign tclk = sel ? tosc : clk;
  assign ld   = cap ^ ack;
  assign run  = |ctl_t[2:0];
  assign supp = ld[2] | ld[1];

  always_ff @(posedge tclk or negedge rst_n) begin
    if (!rst_n) begin
      cap <= '0; ack <= '0; cnt <= '0; cmp_t <= '0; ctl_t <= '0;
      ovf_tg <= 1'b0; cmp_tg <= 1'b0;
    end else begin
      cap <= req;
      ack <= cap;
      if (ld[0]) ctl_t <= stage[0];
      if (ld[1]) cmp_t <= stage[1];
      if (ld[2]) cnt <= stage[2];
      else if (run) begin
        cnt <= cnt + 1'b1;
        if (&cnt) ovf_tg <= ~ovf_tg;
      end
      if (run && !supp && cnt == cmp_t) cmp_tg <= ~cmp_tg;
    end
  end

  always_comb begin
    case (addr)
      A_CNT:   rdata = cnt;
      A_CMP:   rdata = cmp_t;
      A_CTL:   rdata = ctl_t;
      A_STAT:  rdata = {{(W-4){1'b0}}, sel, busy};
      A_FLAG:  rdata = {{(W-2){1'b0}}, flag};
      A_EN:    rdata = {{(W-2){1'b0}}, en};
      default: rdata = '0;
    endcase
  end

  assign irq_ovf = flag[0] & en[0];
  assign irq_cmp = flag[1] & en[1];

  assert_busy_on_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|wsel) |=> ((busy & $past(wsel)) == $past(wsel)));

  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag[0]) |-> $past(wr_en && addr == A_FLAG && wdata[0]));

  assert_land_R2: assert property (@(posedge tclk) disable iff (!rst_n)
    ld[2] |=> cnt == $past(stage[2]));

  assert_count_step_R6: assert property (@(posedge tclk) disable iff (!rst_n)
    (run && !ld[2]) |=> cnt == $past(cnt) + 1'b1);

  assert_wrap_R7: assert property (@(posedge tclk) disable iff (!rst_n)
    (run && !ld[2] && &cnt) |=> ovf_tg != $past(ovf_tg));

  assert_no_match_in_flight_R9: assert property (@(posedge tclk) disable iff (!rst_n)
    supp |=> $stable(cmp_tg));
endmodule

// File: tb/sim_async_timer.sv
`timescale 1ns/1ps
module sim_async_timer;
  logic clk = 1'b0, rst_n = 1'b0, tosc = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0, rdata;
  logic irq_ovf, irq_cmp;
  int nchk = 0, nfail = 0;
  bit done = 0;

  async_timer u0 (.clk(clk), .rst_n(rst_n), .tosc(tosc), .wr_en(wr_en), .addr(addr),
                  .wdata(wdata), .rdata(rdata), .irq_ovf(irq_ovf), .irq_cmp(irq_cmp));

  always #10 clk = ~clk;
  initial begin #3.5; forever #86.5 tosc = ~tosc; end

  task automatic check(input string what, input logic [7:0] got, input logic [7:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [7:0] s;
    for (int n = 0; n < 400; n++) begin
      rd(3'd3, s);
      if (s[2:0] == 3'b000) break;
      @(negedge clk);
    end
    check({tag, " busy clears"}, {5'd0, s[2:0]}, 8'h00);
  endtask

  task automatic sample_tosc();
    @(posedge tosc); #100;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v0, s;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    for (int a = 0; a < 6; a++) begin
      rd(a[2:0], v); check($sformatf("R12 reset addr %0d", a), v, 8'h00);
    end
    check("R12 irq_ovf reset", {7'd0, irq_ovf}, 8'h00);
    check("R12 irq_cmp reset", {7'd0, irq_cmp}, 8'h00);

    // R5/R3 sweep on system clock: count and compare land independently
    for (int i = 0; i < 256; i++) begin
      wr(3'd0, i[7:0]);
      wr(3'd1, ~i[7:0]);
      wait_idle("R3 sweep");
      rd(3'd0, v); check("R3 count sweep", v, i[7:0]);
      rd(3'd1, v); check("R3 compare sweep", v, ~i[7:0]);
    end

    // R5/R6 counting on system clock
    wr(3'd2, 8'h01); wait_idle("R5 ctl");
    rd(3'd0, v0);
    repeat (10) @(negedge clk);
    rd(3'd0, v); check("R5 counts per system clock", v, v0 + 8'd10);
    wr(3'd2, 8'h00); wait_idle("R6 stop");
    rd(3'd0, v0);
    repeat (10) @(negedge clk);
    rd(3'd0, v); check("R6 stopped holds", v, v0);
    wr(3'd4, 8'h03);

    // R5 select oscillator
    wr(3'd3, 8'h08);
    rd(3'd3, v); check("R5 clock select readback", v, 8'h08);

    // R1/R2 landing on second oscillator edge
    @(posedge tosc); #20;
    wr(3'd0, 8'h5A);
    rd(3'd3, v); check("R1 count busy set", v, 8'h0C);
    rd(3'd0, v); check("R2 old count before edges", v, v0);
    @(posedge tosc); #5;
    rd(3'd0, v); check("R2 old count after one edge", v, v0);
    rd(3'd3, v); check("R1 still busy after one edge", v, 8'h0C);
    @(posedge tosc); #5;
    rd(3'd0, v); check("R2 count after two edges", v, 8'h5A);
    wait_idle("R1 count");

    // R3 three writes back to back
    wr(3'd0, 8'h21); wr(3'd1, 8'h42); wr(3'd2, 8'hF0);
    rd(3'd3, v); check("R1 all three busy", v, 8'h0F);
    wait_idle("R3 trio");
    rd(3'd0, v); check("R3 count", v, 8'h21);
    rd(3'd1, v); check("R3 compare", v, 8'h42);
    rd(3'd2, v); check("R3 control", v, 8'hF0);

    // R4 rewrite before pickup and after landing
    wr(3'd0, 8'h11); wr(3'd0, 8'h22); wait_idle("R4 early");
    rd(3'd0, v); check("R4 early rewrite", v, 8'h22);
    @(posedge tosc); #20;
    wr(3'd0, 8'h33);
    @(posedge tosc); @(posedge tosc); @(negedge clk);
    wr(3'd0, 8'h44);
    rd(3'd3, v); check("R4 busy during late rewrite", v, 8'h0C);
    wait_idle("R4 late");
    rd(3'd0, v); check("R4 late rewrite", v, 8'h44);

    // R6/R7/R8 counting on oscillator
    wr(3'd0, 8'hFA); wr(3'd1, 8'hFD); wait_idle("R7 setup");
    wr(3'd4, 8'h03);
    rd(3'd4, v); check("R10 flags cleared", v, 8'h00);
    wr(3'd2, 8'h01); wait_idle("R7 start");
    rd(3'd0, v); check("R6 start value", v, 8'hFA);
    for (int m = 1; m <= 12; m++) begin
      sample_tosc();
      rd(3'd0, v); check($sformatf("R6 count step %0d", m), v, 8'hFA + m[7:0]);
      seen = 0;
      for (int k = 0; k < m; k++) if (8'(8'hFA + k) == 8'hFD) seen = 1;
      rd(3'd4, v);
      check($sformatf("R7 overflow at step %0d", m), {7'd0, v[0]}, {7'd0, (250 + m) > 255});
      check($sformatf("R8 compare at step %0d", m), {7'd0, v[1]}, {7'd0, seen});
    end
    wr(3'd2, 8'h00); wait_idle("R6 osc stop");
    rd(3'd0, v0);
    repeat (3) @(posedge tosc); #20;
    rd(3'd0, v); check("R6 stopped on oscillator", v, v0);

    // R11 gating
    for (int e = 0; e < 4; e++) begin
      wr(3'd5, e[7:0]);
      #1;
      check($sformatf("R11 irq_ovf en=%0d", e), {7'd0, irq_ovf}, {7'd0, e[0]});
      check($sformatf("R11 irq_cmp en=%0d", e), {7'd0, irq_cmp}, {7'd0, e[1]});
    end

    // R10 write-one-to-clear
    wr(3'd4, 8'h00); rd(3'd4, v); check("R10 zero write keeps flags", v, 8'h03);
    wr(3'd4, 8'h01); rd(3'd4, v); check("R10 clear overflow only", v, 8'h02);
    check("R11 irq_cmp still set", {7'd0, irq_cmp}, 8'h01);
    wr(3'd4, 8'h02); rd(3'd4, v); check("R10 clear compare", v, 8'h00);
    check("R11 irqs low after clear", {6'd0, irq_cmp, irq_ovf}, 8'h00);

    // R9 compare suppressed while count write in flight
    wr(3'd0, 8'h00); wr(3'd1, 8'h01); wait_idle("R9 setup");
    wr(3'd4, 8'h03);
    wr(3'd2, 8'h01); wait_idle("R9 start");
    wr(3'd0, 8'h80);
    repeat (4) sample_tosc();
    rd(3'd4, v); check("R9 no match while in flight", v, 8'h00);
    rd(3'd0, v); check("R9 count after reload", v, 8'h82);

    // R12 reset mid-run
    wr(3'd5, 8'h03);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int a = 0; a < 6; a++) begin
      rd(a[2:0], v); check($sformatf("R12 after reset addr %0d", a), v, 8'h00);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule